// File: doc/BRIEF.md
# Channel Power-Down Controller

This block keeps the power-down state of a bank of output channels and gives the analog side a two-bit mode code for each channel. Each code is one of four values: active, high impedance, 1 kΩ to ground or 100 kΩ to ground. An upstream command decoder sends it power-down commands. A command holds a strobe, a flag that chooses one channel or a group of channels, a channel select and a two-bit mode request. The decoder also sends a per-channel load mask. The mask is raised whenever a normal data write loads a channel's output register, and that write brings the channel back to active.

An active-low global power-down pin sets every channel to high impedance at once. This override works combinationally and leaves the stored per-channel state untouched. When the pin goes high again, each channel shows the state it held before, or any state that later commands have written into it since. An asynchronous active-low reset clears all stored state to active.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: After reset every channel reports code 00 (active). The mode output codes are 00 active, 01 high impedance, 10 1 kΩ and 11 100 kΩ, with channel i in bits [2i+1:2i].
- R2: A power-down command converts its two-bit mode request as follows: 00 gives code 01, 01 gives code 10, 10 gives code 11, and 11 gives code 01.
- R3: When a strobe arrives with the group flag at 0, only the channel whose index equals the select value takes the new code. The new code appears at the output one clock edge after the strobe.
- R4: When a strobe arrives with the group flag at 1, channels 0 through select+1 take the new code. Select values 110 and 111 both cover all eight channels, and select 000 covers channels 0 and 1.
- R5: A channel that is neither targeted by a strobe nor flagged in the load mask keeps its code across the clock edge.
- R6: A set bit in the load mask returns that channel to active (00) at the next clock edge.
- R7: If a power-down command and a load-mask bit hit the same channel in the same cycle, the power-down command wins.
- R8: While the global pin is low, every channel reports code 01 in the same cycle, with no clock edge needed.
- R9: When the global pin goes high, every channel shows its stored code again.
- R10: Strobes and loads that arrive while the global pin is low still update the stored state. The updated state appears when the pin is released.
- R11: Asserting the reset clears every channel to active immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_strobe | input | 1 | Power-down command valid |
| pd_group | input | 1 | 0 selects a single channel, 1 selects a prefix group |
| pd_sel | input | 3 | Channel select or group size |
| pd_mode | input | 2 | Requested power-down mode |
| load_mask | input | 8 | Per-channel data-load strobe (wakes the channel) |
| global_pd_n | input | 1 | Active-low override that forces all channels to high impedance |
| out_mode | output | 16 | Per-channel mode code, two bits per channel |

## Verification
Every stored code drives its own field of the output, so a channel that is stored wrongly shows up one cycle after the command or load that corrupted it. The only exception is while the global pin is low. In that window a wrong code stays hidden behind the forced high impedance and only appears on the first cycle after release, so the bench checks the output right after each release. Errors in the group decoder show up as wrong codes on the channels at the edge of a group. The bench therefore compares all eight fields against a model on every cycle, not only the targeted channel.

// File: rtl/chpd_pkg.sv
package chpd_pkg;

   typedef enum logic [1:0] {
      CH_ACTIVE = 2'b00,
      CH_HIZ    = 2'b01,
      CH_R1K    = 2'b10,
      CH_R100K  = 2'b11
   } ch_mode_e;

   // Converts a command mode request into a stored channel code (R2)
   function automatic ch_mode_e cmd_to_mode(input logic [1:0] req);
      ch_mode_e m;
      case (req)
         2'b01:   m = CH_R1K;
         2'b10:   m = CH_R100K;
         default: m = CH_HIZ;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/chpd_target.sv
module chpd_target #(
   parameter int NUM_CH = 8,
   parameter int SEL_W  = 3
) (
   input  logic              group_n1,
   input  logic [SEL_W-1:0]  sel,
   output logic [NUM_CH-1:0] hit
);
   localparam int TOP_W = SEL_W + 1;

   logic [TOP_W-1:0] top_idx;
   assign top_idx = {1'b0, sel} + TOP_W'(1);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign hit[i] = group_n1 ? (TOP_W'(i) <= top_idx)
                               : ({1'b0, sel} == TOP_W'(i));
   end

   always_comb begin
      if (group_n1)
         assert_prefix_base_R4: assert (hit[1:0] == 2'b11);
      else
         assert_single_onehot_R3: assert ($onehot0(hit));
   end

endmodule

// File: rtl/chpd_store.sv
module chpd_store
   import chpd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set,
   input  ch_mode_e set_mode,
   input  logic     wake,
   output ch_mode_e state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= CH_ACTIVE;
      else if (set)
         state <= set_mode;
      else if (wake)
         state <= CH_ACTIVE;
   end

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> state == $past(set_mode));

   assert_wake_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !set) |=> state == CH_ACTIVE);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !wake) |=> $stable(state));

endmodule

// File: rtl/chpd_override.sv
module chpd_override #(
   parameter int NUM_CH = 8
) (
   input  logic                  global_pd_n,
   input  logic [2*NUM_CH-1:0]   stored,
   output logic [2*NUM_CH-1:0]   shown
);
   import chpd_pkg::*;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ovr
      assign shown[2*i +: 2] = global_pd_n ? stored[2*i +: 2] : 2'(CH_HIZ);
   end

endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl
   import chpd_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int SEL_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pd_strobe,
   input  logic                 pd_group,
   input  logic [SEL_W-1:0]     pd_sel,
   input  logic [1:0]           pd_mode,
   input  logic [NUM_CH-1:0]    load_mask,
   input  logic                 global_pd_n,
   output logic [2*NUM_CH-1:0]  out_mode
);
   localparam int OUT_W = 2 * NUM_CH;

   if (NUM_CH < 2 || NUM_CH > (1 << SEL_W)) begin : g_bad_cfg
      $error("chan_pwr_ctrl: NUM_CH must lie in 2..2**SEL_W");
   end

   logic [NUM_CH-1:0] hit;
   ch_mode_e          req_mode;
   ch_mode_e          stored [NUM_CH];
   logic [OUT_W-1:0]  stored_flat;

   assign req_mode = cmd_to_mode(pd_mode);

   chpd_target #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_target (
      .group_n1 (pd_group),
      .sel      (pd_sel),
      .hit      (hit)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chpd_store u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .set      (pd_strobe && hit[i]),
         .set_mode (req_mode),
         .wake     (load_mask[i]),
         .state    (stored[i])
      );
      assign stored_flat[2*i +: 2] = stored[i];
   end

   chpd_override #(.NUM_CH(NUM_CH)) u_ovr (
      .global_pd_n (global_pd_n),
      .stored      (stored_flat),
      .shown       (out_mode)
   );

   assert_global_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !global_pd_n |-> out_mode == {NUM_CH{2'b01}});

   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(global_pd_n) |-> out_mode == stored_flat);

   assert_strobe_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_strobe && !pd_group && pd_sel == '0) |=> stored[0] == $past(req_mode));

endmodule

// File: tb/chan_pwr_ctrl_test.sv
`timescale 1ns/1ps
module chan_pwr_ctrl_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pd_strobe = 1'b0;
   logic        pd_group = 1'b0;
   logic [2:0]  pd_sel = '0;
   logic [1:0]  pd_mode = '0;
   logic [N-1:0] load_mask = '0;
   logic        global_pd_n = 1'b1;
   logic [2*N-1:0] out_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [1:0] model [N];

   always #2.5 clk = ~clk;

   chan_pwr_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pd_strobe(pd_strobe), .pd_group(pd_group),
      .pd_sel(pd_sel), .pd_mode(pd_mode), .load_mask(load_mask),
      .global_pd_n(global_pd_n), .out_mode(out_mode)
   );

   function automatic logic [1:0] exp_code(input logic [1:0] req);
      case (req)
         2'b00: return 2'b01;
         2'b01: return 2'b10;
         2'b10: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   function automatic bit exp_hit(input bit grp, input logic [2:0] s, input int i);
      if (grp) return i <= int'(s) + 1;
      return i == int'(s);
   endfunction

   function automatic logic [2*N-1:0] exp_out();
      logic [2*N-1:0] v;
      for (int i = 0; i < N; i++)
         v[2*i +: 2] = global_pd_n ? model[i] : 2'b01;
      return v;
   endfunction

   task automatic check(input string req);
      logic [2*N-1:0] e;
      e = exp_out();
      checks++;
      if (out_mode !== e) begin
         errors++;
         $display("FAIL %s: out_mode actual=%h expected=%h", req, out_mode, e);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < N; i++) model[i] = 2'b00;
   endtask

   // One clock: apply inputs, update the model at the edge, check just after it
   task automatic cyc(input bit stb, input bit grp, input logic [2:0] s,
                      input logic [1:0] m, input logic [N-1:0] ld, input string req);
      pd_strobe = stb; pd_group = grp; pd_sel = s; pd_mode = m; load_mask = ld;
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         if (stb && exp_hit(grp, s, i)) model[i] = exp_code(m);
         else if (ld[i])                model[i] = 2'b00;
      end
      #1;
      pd_strobe = 1'b0; load_mask = '0;
      check(req);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      clear_model();
      #12 rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 reset state");

      // R2 mapping, R3 single channel
      cyc(1, 0, 3'd0, 2'b00, '0, "R2 R3 req00 ch0");
      cyc(1, 0, 3'd1, 2'b01, '0, "R2 R3 req01 ch1");
      cyc(1, 0, 3'd2, 2'b10, '0, "R2 R3 req10 ch2");
      cyc(1, 0, 3'd7, 2'b11, '0, "R2 R3 req11 ch7");
      cyc(0, 0, 3'd0, 2'b00, '0, "R5 idle hold");
      // R6 wake
      cyc(0, 0, 3'd0, 2'b00, 8'h05, "R6 load wakes ch0 ch2");
      // R4 groups
      cyc(1, 1, 3'd0, 2'b01, '0, "R4 group sel000");
      cyc(0, 0, 3'd0, 2'b00, 8'hFF, "R6 load all");
      cyc(1, 1, 3'd5, 2'b10, '0, "R4 group sel101");
      cyc(0, 0, 3'd0, 2'b00, 8'hFF, "R6 load all");
      cyc(1, 1, 3'd6, 2'b01, '0, "R4 group sel110");
      cyc(1, 1, 3'd7, 2'b10, '0, "R4 group sel111");
      // R7 conflict
      cyc(1, 0, 3'd3, 2'b01, 8'h0C, "R7 command beats load");
      // R8 / R10 / R9
      #1 global_pd_n = 1'b0;
      #1 check("R8 global low immediate");
      cyc(1, 0, 3'd4, 2'b00, '0, "R8 R10 strobe under global low");
      cyc(0, 0, 3'd0, 2'b00, 8'h01, "R8 R10 load under global low");
      #1 global_pd_n = 1'b1;
      #1 check("R9 R10 release shows stored");
      // R11 async reset mid-cycle
      #1 rst_n = 1'b0;
      clear_model();
      #0.5 check("R11 async clear");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after reset release");

      // constrained random
      for (int k = 0; k < 600; k++) begin
         bit stb, grp;
         logic [N-1:0] ld;
         stb = ($urandom % 3) == 0;
         grp = $urandom % 2;
         ld  = N'($urandom) & N'($urandom) & N'($urandom);
         if (($urandom % 10) == 0) global_pd_n = ~global_pd_n;
         cyc(stb, grp, 3'($urandom), 2'($urandom), ld, "R2 R3 R4 R5 R6 R9 R10 random");
      end
      global_pd_n = 1'b1;
      #1 check("R9 final release");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule